// File: doc/BRIEF.md
# USB Endpoint Stall Control Register

This block holds an 8-bit CPU-writable register that forces a small USB function's endpoints into a stalled state. It also turns each stall bit into the reply the serial engine should give when a token reaches that endpoint. The function has these endpoints:

- a control endpoint (endpoint 0, both directions);
- a bulk/interrupt IN on endpoint 1;
- an IN/OUT pair on endpoint 2;
- an isochronous IN/OUT pair on endpoint 3.

Isochronous endpoints never answer with a STALL handshake. A stalled isochronous IN sends one zero-length packet and then stays silent. A stalled isochronous OUT drops its data and gives no handshake. The control-endpoint stall clears itself when a decoded setup command arrives, and a CPU write of 1 to it is refused while a setup event is pending.

The isochronous IN behaviour is driven by a three-state machine:

| State | Meaning |
|---|---|
| ISO_OFF | The isochronous IN stall bit is clear. |
| ISO_ARMED | The bit is set and no IN token has been answered yet. |
| ISO_MUTED | The zero-length packet has been sent. |

Its transitions are:

| Transition | From | To | Condition |
|---|---|---|---|
| arm | ISO_OFF | ISO_ARMED | The bit is set and no token arrives. |
| fire | ISO_OFF or ISO_ARMED | ISO_MUTED | The bit is set and an isochronous IN token is answered. |
| disarm | ISO_ARMED or ISO_MUTED | ISO_OFF | The bit reads 0. |
| hold | any state | the same state | None of the above applies. |

A token presented in one cycle gets its response code registered on the next rising edge.

Top module: `usb_stall_ctl`

## Requirements
- R1: After reset the register reads 0x00, `resp_valid` is 0 and `resp_code` is 00.
- R2: A CPU write loads bits 7 (isochronous OUT), 6 (isochronous IN), 5 (endpoint 2 OUT), 4 (endpoint 2 IN), 3 (endpoint 1 IN) and 0 (control endpoint). A write of 0 to a bit cancels that stall. `cpu_rdata` shows the register at all times.
- R3: Bits 2 and 1 always read 0, and writes to them have no effect.
- R4: A token for a non-isochronous endpoint whose stall bit is 1 gets code 01 (STALL). Bit 0 covers both directions of endpoint 0.
- R5: A token for an endpoint whose stall bit is 0 gets code 00 (normal). So does a token for an endpoint that has no stall bit (endpoint 1 OUT).
- R6: `resp_valid` is 1 in exactly the cycle after a cycle with `tok_valid`=1, and `resp_code` holds the code for that token.
- R7: A token for endpoint 3 never gets code 01.
- R8: While bit 6 is 1, the first endpoint 3 IN token gets code 10 (zero-length packet). Every later endpoint 3 IN token gets code 11 (no reply).
- R9: If bit 6 reads 0 for at least one cycle and is then set again, the next endpoint 3 IN token once more gets code 10.
- R10: While bit 7 is 1, an endpoint 3 OUT token gets code 11.
- R11: A pulse on `setup_cmd_rx` clears bit 0 at the next edge.
- R12: While `setup_pending` is 1, a CPU write of 1 to bit 0 leaves bit 0 unchanged, a write of 0 still clears it, and the other bits are written normally.
- R13: If `setup_cmd_rx` and a CPU write of 1 to bit 0 fall in the same cycle, bit 0 ends up 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_wr_en | input | 1 | CPU write strobe for the stall register |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | Current register value |
| setup_cmd_rx | input | 1 | One-cycle pulse: a decoded setup command has been received |
| setup_pending | input | 1 | Setup event flag still pending |
| tok_valid | input | 1 | A token is presented this cycle |
| tok_ep | input | 2 | Endpoint number of the token |
| tok_in | input | 1 | 1 = IN token, 0 = OUT/SETUP token |
| resp_valid | output | 1 | Response code is valid |
| resp_code | output | 2 | 00 normal, 01 STALL, 10 zero-length packet, 11 no reply |

## Verification
The embedded assertions check the following on every cycle:
- the one-cycle response timing;
- that endpoint 3 never produces a STALL;
- the hardware clear of bit 0 and the refusal of a pending write;
- the endpoint 2 OUT stall mapping;
- the return of the isochronous IN machine to ISO_OFF when its bit drops.

Only the bench's scenarios show the ordering behaviour: the single zero-length packet followed by silence, re-arming after the bit is cleared and set again, the precedence of a same-cycle clear, and reserved bits surviving a full-ones write as zeros.

// File: rtl/usb_stall_pkg.sv
package usb_stall_pkg;
    localparam int REG_W   = 8;
    localparam int EP_W    = 2;
    localparam int CODE_W  = 2;

    localparam int BIT_CTL  = 0;
    localparam int BIT_E1I  = 3;
    localparam int BIT_E2I  = 4;
    localparam int BIT_E2O  = 5;
    localparam int BIT_ISOI = 6;
    localparam int BIT_ISOO = 7;

    localparam logic [REG_W-1:0] WR_MASK = REG_W'(8'hF9);

    localparam logic [EP_W-1:0] EP_CTL = EP_W'(0);
    localparam logic [EP_W-1:0] EP_ONE = EP_W'(1);
    localparam logic [EP_W-1:0] EP_TWO = EP_W'(2);
    localparam logic [EP_W-1:0] EP_ISO = EP_W'(3);

    typedef enum logic [CODE_W-1:0] {
        RESP_NORMAL = 2'b00,
        RESP_STALL  = 2'b01,
        RESP_ZLP    = 2'b10,
        RESP_SILENT = 2'b11
    } resp_e;
endpackage

// File: rtl/stall_bits.sv
module stall_bits
    import usb_stall_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wdata,
    input  logic             setup_cmd_rx,
    input  logic             setup_pending,
    output logic [REG_W-1:0] stall_q
);
    logic [REG_W-1:0] stall_d;

    always_comb begin
        stall_d = stall_q;
        if (wr_en) begin
            stall_d = wdata & WR_MASK;
            // a pending setup blocks only the write of a one
            if (setup_pending && wdata[BIT_CTL])
                stall_d[BIT_CTL] = stall_q[BIT_CTL];
        end
        // hardware clear beats any CPU write
        if (setup_cmd_rx)
            stall_d[BIT_CTL] = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stall_q <= '0;
        else        stall_q <= stall_d;
    end

    p_setup_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        setup_cmd_rx |=> !stall_q[BIT_CTL]);

    p_pending_block_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && setup_pending && !stall_q[BIT_CTL]) |=> !stall_q[BIT_CTL]);

    p_bulk_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> stall_q[REG_W-1:BIT_E1I] == $past(wdata[REG_W-1:BIT_E1I]));
endmodule

// File: rtl/iso_in_tracker.sv
module iso_in_tracker (
    input  logic clk,
    input  logic rst_n,
    input  logic stall_en,
    input  logic in_tok,
    output logic muted
);
    typedef enum logic [1:0] {
        ISO_OFF   = 2'b00,
        ISO_ARMED = 2'b01,
        ISO_MUTED = 2'b10
    } iso_state_e;

    iso_state_e state, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ISO_OFF;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ISO_OFF: begin
                if (stall_en && in_tok) state_nx = ISO_MUTED;
                else if (stall_en)      state_nx = ISO_ARMED;
            end
            ISO_ARMED: begin
                if (!stall_en)   state_nx = ISO_OFF;
                else if (in_tok) state_nx = ISO_MUTED;
            end
            ISO_MUTED: begin
                if (!stall_en) state_nx = ISO_OFF;
            end
            default: state_nx = ISO_OFF;
        endcase
    end

    always_comb muted = (state == ISO_MUTED);

    p_disarm_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !stall_en |=> state == ISO_OFF);

    p_fire_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (stall_en && in_tok) |=> state == ISO_MUTED);
endmodule

// File: rtl/resp_encoder.sv
module resp_encoder
    import usb_stall_pkg::*;
(
    input  logic [REG_W-1:0] stall_q,
    input  logic [EP_W-1:0]  tok_ep,
    input  logic             tok_in,
    input  logic             iso_muted,
    output resp_e            code
);
    always_comb begin
        code = RESP_NORMAL;
        unique case (tok_ep)
            EP_CTL: if (stall_q[BIT_CTL]) code = RESP_STALL;
            EP_ONE: if (tok_in && stall_q[BIT_E1I]) code = RESP_STALL;
            EP_TWO: begin
                if (tok_in ? stall_q[BIT_E2I] : stall_q[BIT_E2O]) code = RESP_STALL;
            end
            EP_ISO: begin
                if (tok_in) begin
                    if (stall_q[BIT_ISOI]) code = iso_muted ? RESP_SILENT : RESP_ZLP;
                end else if (stall_q[BIT_ISOO]) begin
                    code = RESP_SILENT;
                end
            end
            default: code = RESP_NORMAL;
        endcase
    end
endmodule

// File: rtl/usb_stall_ctl.sv
module usb_stall_ctl
    import usb_stall_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_wr_en,
    input  logic [REG_W-1:0]  cpu_wdata,
    output logic [REG_W-1:0]  cpu_rdata,
    input  logic              setup_cmd_rx,
    input  logic              setup_pending,
    input  logic              tok_valid,
    input  logic [EP_W-1:0]   tok_ep,
    input  logic              tok_in,
    output logic              resp_valid,
    output logic [CODE_W-1:0] resp_code
);
    logic [REG_W-1:0] stall_q;
    logic             iso_muted;
    resp_e            code_c;

    stall_bits u_bits (
        .clk(clk), .rst_n(rst_n), .wr_en(cpu_wr_en), .wdata(cpu_wdata),
        .setup_cmd_rx(setup_cmd_rx), .setup_pending(setup_pending),
        .stall_q(stall_q)
    );

    iso_in_tracker u_iso (
        .clk(clk), .rst_n(rst_n), .stall_en(stall_q[BIT_ISOI]),
        .in_tok(tok_valid && tok_in && (tok_ep == EP_ISO)),
        .muted(iso_muted)
    );

    resp_encoder u_enc (
        .stall_q(stall_q), .tok_ep(tok_ep), .tok_in(tok_in),
        .iso_muted(iso_muted), .code(code_c)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            resp_valid <= 1'b0;
            resp_code  <= RESP_NORMAL;
        end else begin
            resp_valid <= tok_valid;
            resp_code  <= tok_valid ? code_c : RESP_NORMAL;
        end
    end

    assign cpu_rdata = stall_q;

    p_resp_follows_r6: assert property (@(posedge clk) disable iff (!rst_n)
        tok_valid |=> resp_valid);

    p_resp_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !tok_valid |=> !resp_valid);

    p_iso_no_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (tok_valid && tok_ep == EP_ISO) |=> resp_code != RESP_STALL);

    p_ep2_out_stall_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tok_valid && tok_ep == EP_TWO && !tok_in && cpu_rdata[BIT_E2O]) |=> resp_code == RESP_STALL);
endmodule

// File: tb/usb_stall_ctl_test.sv
module usb_stall_ctl_test;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 17;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cpu_wr_en = 1'b0;
    logic [7:0] cpu_wdata = '0;
    logic [7:0] cpu_rdata;
    logic       setup_cmd_rx = 1'b0;
    logic       setup_pending = 1'b0;
    logic       tok_valid = 1'b0;
    logic [1:0] tok_ep = '0;
    logic       tok_in = 1'b0;
    logic       resp_valid;
    logic [1:0] resp_code;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    usb_stall_ctl uut (
        .clk(clk), .rst_n(rst_n), .cpu_wr_en(cpu_wr_en), .cpu_wdata(cpu_wdata),
        .cpu_rdata(cpu_rdata), .setup_cmd_rx(setup_cmd_rx),
        .setup_pending(setup_pending), .tok_valid(tok_valid), .tok_ep(tok_ep),
        .tok_in(tok_in), .resp_valid(resp_valid), .resp_code(resp_code)
    );

    // {write, wdata, ep, in, expected code}; 00 normal 01 stall 10 zlp 11 silent
    localparam logic [13:0] VEC [NVEC] = '{
        {1'b1, 8'h08, 2'd1, 1'b1, 2'b01},  // R4 ep1 IN stalled
        {1'b0, 8'h00, 2'd1, 1'b0, 2'b00},  // R5 ep1 OUT has no bit
        {1'b1, 8'h30, 2'd2, 1'b0, 2'b01},  // R4 ep2 OUT
        {1'b0, 8'h00, 2'd2, 1'b1, 2'b01},  // R4 ep2 IN
        {1'b0, 8'h00, 2'd1, 1'b1, 2'b00},  // R2 ep1 stall cancelled
        {1'b1, 8'h01, 2'd0, 1'b1, 2'b01},  // R4 ctl IN
        {1'b0, 8'h00, 2'd0, 1'b0, 2'b01},  // R4 ctl OUT
        {1'b1, 8'h80, 2'd3, 1'b0, 2'b11},  // R10 iso OUT silent
        {1'b0, 8'h00, 2'd3, 1'b1, 2'b00},  // R5 iso IN not stalled
        {1'b1, 8'h00, 2'd3, 1'b0, 2'b00},  // R5 iso OUT cleared
        {1'b1, 8'h40, 2'd3, 1'b1, 2'b10},  // R8 first IN zlp
        {1'b0, 8'h00, 2'd3, 1'b1, 2'b11},  // R8 then silent
        {1'b0, 8'h00, 2'd3, 1'b1, 2'b11},  // R8 still silent
        {1'b0, 8'h00, 2'd3, 1'b0, 2'b00},  // R7 iso OUT normal
        {1'b1, 8'h00, 2'd3, 1'b1, 2'b00},  // R9 cleared
        {1'b1, 8'h40, 2'd3, 1'b1, 2'b10},  // R9 re-armed
        {1'b1, 8'h06, 2'd0, 1'b0, 2'b00}   // R3 reserved write, ctl normal
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic cpu_write(input logic [7:0] d);
        cpu_wr_en = 1'b1;
        cpu_wdata = d;
        @(negedge clk);
        cpu_wr_en = 1'b0;
    endtask

    task automatic send_tok(input logic [1:0] ep, input logic dir_in);
        tok_valid = 1'b1;
        tok_ep = ep;
        tok_in = dir_in;
        @(negedge clk);
        tok_valid = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 rdata", cpu_rdata, 8'h00);
        check("R1 resp_valid", {7'd0, resp_valid}, 8'h00);
        check("R1 resp_code", {6'd0, resp_code}, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NVEC; i++) begin
            if (VEC[i][13]) cpu_write(VEC[i][12:5]);
            send_tok(VEC[i][4:3], VEC[i][2]);
            check($sformatf("R6 valid vec %0d", i), {7'd0, resp_valid}, 8'h01);
            check($sformatf("R4/R5/R7/R8/R9/R10 code vec %0d", i), {6'd0, resp_code}, {6'd0, VEC[i][1:0]});
        end

        // R6: no token, no response
        @(negedge clk);
        check("R6 idle", {7'd0, resp_valid}, 8'h00);

        // R2 and R3: full write reads back without reserved bits
        cpu_write(8'hFF);
        check("R2 readback", cpu_rdata, 8'hF9);
        check("R3 reserved", {6'd0, cpu_rdata[2:1]}, 8'h00);
        cpu_write(8'h00);
        check("R2 cleared", cpu_rdata, 8'h00);

        // R11 setup clears control stall
        cpu_write(8'h21);
        setup_cmd_rx = 1'b1;
        @(negedge clk);
        setup_cmd_rx = 1'b0;
        check("R11 ctl cleared", cpu_rdata, 8'h20);
        send_tok(2'd0, 1'b0);
        check("R11 ctl token normal", {6'd0, resp_code}, 8'h00);

        // R12 pending blocks write of one, others still written
        setup_pending = 1'b1;
        cpu_write(8'h11);
        check("R12 one ignored", cpu_rdata, 8'h10);
        setup_pending = 1'b0;
        cpu_write(8'h01);
        setup_pending = 1'b1;
        cpu_write(8'h00);
        check("R12 zero clears", cpu_rdata, 8'h00);
        setup_pending = 1'b0;

        // R13 same-cycle setup beats write
        cpu_wr_en = 1'b1;
        cpu_wdata = 8'h09;
        setup_cmd_rx = 1'b1;
        @(negedge clk);
        cpu_wr_en = 1'b0;
        setup_cmd_rx = 1'b0;
        check("R13 clear wins", cpu_rdata, 8'h08);

        // R8 with back-to-back tokens
        cpu_write(8'h40);
        tok_valid = 1'b1; tok_ep = 2'd3; tok_in = 1'b1;
        @(negedge clk);
        check("R8 b2b first", {6'd0, resp_code}, 8'h02);
        @(negedge clk);
        tok_valid = 1'b0;
        check("R8 b2b second", {6'd0, resp_code}, 8'h03);

        finish_run();
    end
endmodule